// File: doc/BRIEF.md
# Branch Resolution and Next-PC Unit

This combinational unit decides where a single-cycle RV32I core fetches next. Each cycle it gets the current program counter, both register operands, the sign-extended immediate, the ALU result and the decoded control-flow flags with the funct3 branch condition. From these it produces the next program counter, the sequential return address that jump instructions write back, a redirect flag and an instruction-address-misaligned exception flag.

The unit has its own comparator for the six conditional-branch relations, so the ALU stays free. It also has its own adder for PC-relative targets. Register-indirect jumps take their target from the ALU result. A redirect to an address that is not a whole instruction apart raises the exception. A branch that is not taken never raises it, even when its encoded offset is misaligned. The next-PC output still shows the computed target, and the core's trap logic decides what to do with it.

Top module: `nxpc_unit`

## Requirements
- R1: `link_pc_o` always equals `pc_i + 4`, whatever the flags say.
- R2: When none of `is_branch_i`, `is_jal_i` and `is_jalr_i` is set, `next_pc_o` equals `pc_i + 4`, and both `taken_o` and `misalign_o` are 0.
- R3: A branch with funct3 000 is taken when the operands are equal. A branch with funct3 001 is taken when they differ.
- R4: A branch with funct3 100 is taken when rs1 is less than rs2 as two's-complement values. A branch with funct3 101 is taken when rs1 is greater than or equal to rs2 as two's-complement values.
- R5: A branch with funct3 110 is taken when rs1 is less than rs2 as unsigned values. A branch with funct3 111 is taken when rs1 is greater than or equal to rs2 as unsigned values.
- R6: A taken branch sets `taken_o` and sends `next_pc_o` to `pc_i + imm_i`. A branch that is not taken clears `taken_o` and sends `next_pc_o` to `pc_i + 4`.
- R7: A branch whose funct3 is 010 or 011 (no defined condition) is never taken.
- R8: A PC-relative jump (`is_jal_i`) sets `taken_o` and sends `next_pc_o` to `pc_i + imm_i`.
- R9: A register-indirect jump (`is_jalr_i`) sets `taken_o` and sends `next_pc_o` to `alu_res_i` with bit 0 forced to 0.
- R10: `misalign_o` is 1 exactly when `taken_o` is 1 and bits [1:0] of `next_pc_o` are not both 0. A branch that is not taken therefore never flags, whatever its offset.
- R11: When more than one control-flow flag is set, the register-indirect jump wins over the PC-relative jump, and the PC-relative jump wins over the branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Program counter of the current instruction |
| rs1_val_i | input | 32 | First register operand |
| rs2_val_i | input | 32 | Second register operand |
| imm_i | input | 32 | Sign-extended immediate (branch or jump offset) |
| alu_res_i | input | 32 | ALU result, the register-plus-immediate sum for indirect jumps |
| funct3_i | input | 3 | Branch condition code |
| is_branch_i | input | 1 | Instruction is a conditional branch |
| is_jal_i | input | 1 | Instruction is a PC-relative jump |
| is_jalr_i | input | 1 | Instruction is a register-indirect jump |
| next_pc_o | output | 32 | Address of the next instruction |
| link_pc_o | output | 32 | Sequential address written back by jumps |
| taken_o | output | 1 | Control flow leaves the sequential path |
| misalign_o | output | 1 | Redirect target is not 4-byte aligned |

## Verification
Some properties hold on every evaluation, and immediate assertions check them each time the inputs change. These are: no exception without a redirect; a non-redirected next PC equal to the link address; bit 0 cleared for indirect jumps; and the comparator never reporting "less than" for equal operands. The scenario tasks are what show that each funct3 code picks the right relation, with signed and unsigned orderings pulling apart on operands whose top bit differs. They also show the selected target value and the flag priority. The same goes for a misaligned but untaken branch staying silent, since these depend on the specific values chosen.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;

  // Branch condition codes; the encoding is fixed by the instruction set.
  typedef enum logic [2:0] {
    COND_EQ  = 3'b000,
    COND_NE  = 3'b001,
    COND_RS2 = 3'b010,
    COND_RS3 = 3'b011,
    COND_LT  = 3'b100,
    COND_GE  = 3'b101,
    COND_LTU = 3'b110,
    COND_GEU = 3'b111
  } br_cond_e;

  // Source picked for the next program counter.
  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_REL = 2'd1,
    SRC_IND = 2'd2
  } pc_src_e;

  // Relations produced by the operand comparator.
  typedef struct packed {
    logic eq;
    logic lt;
    logic ltu;
  } cmp_flags_t;

endpackage

// File: rtl/nxpc_cond.sv
module nxpc_cond
  import nxpc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] op_a_i,
  input  logic [XLEN-1:0] op_b_i,
  input  logic [2:0]      funct3_i,
  output logic            cond_o
);

  localparam int unsigned MSB = XLEN - 1;

  logic [XLEN:0] diff;
  cmp_flags_t    flags;
  br_cond_e      cond;

  // One widened subtraction serves both orderings.
  always_comb begin
    diff      = {1'b0, op_a_i} - {1'b0, op_b_i};
    flags.eq  = (op_a_i == op_b_i);
    flags.ltu = diff[XLEN];
    flags.lt  = (op_a_i[MSB] ^ op_b_i[MSB]) ? op_a_i[MSB] : diff[XLEN];
  end

  always_comb begin
    cond = br_cond_e'(funct3_i);
    unique case (cond)
      COND_EQ:  cond_o = flags.eq;
      COND_NE:  cond_o = ~flags.eq;
      COND_LT:  cond_o = flags.lt;
      COND_GE:  cond_o = ~flags.lt;
      COND_LTU: cond_o = flags.ltu;
      COND_GEU: cond_o = ~flags.ltu;
      default:  cond_o = 1'b0;
    endcase
  end

  // R4 R5: equal operands are never ordered below one another
  always_comb begin
    if (flags.eq) begin
      eq_order_chk: assert (!flags.lt && !flags.ltu)
        else $error("comparator orders equal operands");
    end
  end

endmodule

// File: rtl/nxpc_target.sv
module nxpc_target #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic [XLEN-1:0] alu_res_i,
  output logic [XLEN-1:0] seq_pc_o,
  output logic [XLEN-1:0] rel_pc_o,
  output logic [XLEN-1:0] ind_pc_o,
  output logic            rel_mis_o,
  output logic            ind_mis_o
);

  localparam int unsigned STEP = 1 << ALIGN_BITS;
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  always_comb begin
    seq_pc_o = pc_i + STEP_V;
    rel_pc_o = pc_i + imm_i;
    ind_pc_o = {alu_res_i[XLEN-1:1], 1'b0};
  end

  generate
    if (ALIGN_BITS > 0) begin : g_align
      always_comb begin
        rel_mis_o = |rel_pc_o[ALIGN_BITS-1:0];
        ind_mis_o = |ind_pc_o[ALIGN_BITS-1:0];
      end
    end else begin : g_noalign
      always_comb begin
        rel_mis_o = 1'b0;
        ind_mis_o = 1'b0;
      end
    end
  endgenerate

  // R9: indirect target always has bit 0 cleared
  always_comb begin
    ind_even_chk: assert (ind_pc_o[0] == 1'b0)
      else $error("indirect target bit 0 set");
  end

endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
  import nxpc_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] rs1_val_i,
  input  logic [XLEN-1:0] rs2_val_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic [XLEN-1:0] alu_res_i,
  input  logic [2:0]      funct3_i,
  input  logic            is_branch_i,
  input  logic            is_jal_i,
  input  logic            is_jalr_i,
  output logic [XLEN-1:0] next_pc_o,
  output logic [XLEN-1:0] link_pc_o,
  output logic            taken_o,
  output logic            misalign_o
);

  logic            cond;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] rel_pc;
  logic [XLEN-1:0] ind_pc;
  logic            rel_mis;
  logic            ind_mis;
  pc_src_e         src;

  nxpc_cond #(.XLEN(XLEN)) u_cond (
    .op_a_i   (rs1_val_i),
    .op_b_i   (rs2_val_i),
    .funct3_i (funct3_i),
    .cond_o   (cond)
  );

  nxpc_target #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_target (
    .pc_i      (pc_i),
    .imm_i     (imm_i),
    .alu_res_i (alu_res_i),
    .seq_pc_o  (seq_pc),
    .rel_pc_o  (rel_pc),
    .ind_pc_o  (ind_pc),
    .rel_mis_o (rel_mis),
    .ind_mis_o (ind_mis)
  );

  // Source selection; indirect jump has top priority, then relative jump.
  always_comb begin
    if (is_jalr_i)                src = SRC_IND;
    else if (is_jal_i)            src = SRC_REL;
    else if (is_branch_i && cond) src = SRC_REL;
    else                          src = SRC_SEQ;
  end

  always_comb begin
    link_pc_o = seq_pc;
    unique case (src)
      SRC_IND: begin
        next_pc_o  = ind_pc;
        taken_o    = 1'b1;
        misalign_o = ind_mis;
      end
      SRC_REL: begin
        next_pc_o  = rel_pc;
        taken_o    = 1'b1;
        misalign_o = rel_mis;
      end
      default: begin
        next_pc_o  = seq_pc;
        taken_o    = 1'b0;
        misalign_o = 1'b0;
      end
    endcase
  end

  always_comb begin
    // R10
    mis_needs_taken_chk: assert (!misalign_o || taken_o)
      else $error("misalignment without redirect");
    // R6
    if (!taken_o) begin
      seq_path_chk: assert (next_pc_o == link_pc_o)
        else $error("sequential path does not match link address");
    end
    // R2
    if (!is_branch_i && !is_jal_i && !is_jalr_i) begin
      plain_no_redirect_chk: assert (!taken_o && !misalign_o)
        else $error("plain instruction redirected");
    end
  end

endmodule

// File: tb/tb_nxpc_unit.sv
module tb_nxpc_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic [31:0] pc, rs1, rs2, imm, alu;
  logic [2:0]  f3;
  logic        isb, isj, isjr;
  logic [31:0] next_pc, link_pc;
  logic        taken, misalign;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  nxpc_unit dut (
    .pc_i        (pc),
    .rs1_val_i   (rs1),
    .rs2_val_i   (rs2),
    .imm_i       (imm),
    .alu_res_i   (alu),
    .funct3_i    (f3),
    .is_branch_i (isb),
    .is_jal_i    (isj),
    .is_jalr_i   (isjr),
    .next_pc_o   (next_pc),
    .link_pc_o   (link_pc),
    .taken_o     (taken),
    .misalign_o  (misalign)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] p, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] im, input logic [31:0] al, input logic [2:0] fn,
                       input logic br, input logic j, input logic jr);
    @(posedge clk);
    pc = p; rs1 = a; rs2 = b; imm = im; alu = al; f3 = fn;
    isb = br; isj = j; isjr = jr;
    @(negedge clk);
  endtask

  task automatic branch_case(input string req, input logic [2:0] fn,
                             input logic [31:0] a, input logic [31:0] b, input bit exp_tk);
    drive(32'h0000_1000, a, b, 32'h0000_0040, 32'h0, fn, 1'b1, 1'b0, 1'b0);
    chk(req, {31'b0, taken}, {31'b0, exp_tk});
    chk(req, next_pc, exp_tk ? 32'h0000_1040 : 32'h0000_1004);
  endtask

  task automatic t_reset_state();
    drive(32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 3'b000, 1'b0, 1'b0, 1'b0);
    chk("R2 idle next", next_pc, 32'h4);
    chk("R2 idle taken", {31'b0, taken}, 32'h0);
    chk("R1 idle link", link_pc, 32'h4);
  endtask

  task automatic t_sequential();
    // R2: misaligned immediate and ALU value must not matter
    drive(32'h8000_0010, 32'h5, 32'h5, 32'h0000_0003, 32'h0000_0007, 3'b000, 1'b0, 1'b0, 1'b0);
    chk("R2 next", next_pc, 32'h8000_0014);
    chk("R2 taken", {31'b0, taken}, 32'h0);
    chk("R2 misalign", {31'b0, misalign}, 32'h0);
    chk("R1 link", link_pc, 32'h8000_0014);
    drive(32'hFFFF_FFFC, 32'h0, 32'h0, 32'h0, 32'h0, 3'b000, 1'b0, 1'b0, 1'b0);
    chk("R1 wrap", link_pc, 32'h0);
  endtask

  task automatic t_equality();
    branch_case("R3 beq eq", 3'b000, 32'h1234, 32'h1234, 1'b1);
    branch_case("R3 beq ne", 3'b000, 32'h1234, 32'h1235, 1'b0);
    branch_case("R3 bne ne", 3'b001, 32'h1234, 32'h1235, 1'b1);
    branch_case("R3 bne eq", 3'b001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_signed();
    branch_case("R4 blt neg<pos", 3'b100, 32'hFFFF_FFFF, 32'h1, 1'b1);
    branch_case("R4 blt pos<neg", 3'b100, 32'h1, 32'hFFFF_FFFF, 1'b0);
    branch_case("R4 blt equal", 3'b100, 32'h8000_0000, 32'h8000_0000, 1'b0);
    branch_case("R4 bge equal", 3'b101, 32'h8000_0000, 32'h8000_0000, 1'b1);
    branch_case("R4 bge pos>=neg", 3'b101, 32'h7FFF_FFFF, 32'h8000_0000, 1'b1);
    branch_case("R4 bge neg", 3'b101, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0);
  endtask

  task automatic t_unsigned();
    branch_case("R5 bltu big", 3'b110, 32'hFFFF_FFFF, 32'h1, 1'b0);
    branch_case("R5 bltu small", 3'b110, 32'h1, 32'hFFFF_FFFF, 1'b1);
    branch_case("R5 bgeu big", 3'b111, 32'hFFFF_FFFF, 32'h1, 1'b1);
    branch_case("R5 bgeu equal", 3'b111, 32'h10, 32'h10, 1'b1);
    branch_case("R5 bgeu small", 3'b111, 32'h0, 32'h10, 1'b0);
  endtask

  task automatic t_taken_target();
    // R6: negative offset
    drive(32'h0000_2000, 32'h7, 32'h7, 32'hFFFF_FFF0, 32'h0, 3'b000, 1'b1, 1'b0, 1'b0);
    chk("R6 back target", next_pc, 32'h0000_1FF0);
    chk("R6 misalign", {31'b0, misalign}, 32'h0);
  endtask

  task automatic t_reserved();
    branch_case("R7 f3=010", 3'b010, 32'h3, 32'h3, 1'b0);
    branch_case("R7 f3=011", 3'b011, 32'h0, 32'h9, 1'b0);
  endtask

  task automatic t_jal();
    drive(32'h0000_4000, 32'h0, 32'h0, 32'hFFF0_0000, 32'h0, 3'b000, 1'b0, 1'b1, 1'b0);
    chk("R8 target", next_pc, 32'hFFF0_4000);
    chk("R8 taken", {31'b0, taken}, 32'h1);
    chk("R1 jal link", link_pc, 32'h0000_4004);
  endtask

  task automatic t_jalr();
    drive(32'h0000_4000, 32'h0, 32'h0, 32'h0, 32'h0000_9005, 3'b000, 1'b0, 1'b0, 1'b1);
    chk("R9 bit0 cleared", next_pc, 32'h0000_9004);
    chk("R9 taken", {31'b0, taken}, 32'h1);
    chk("R10 jalr aligned", {31'b0, misalign}, 32'h0);
    drive(32'h0000_4000, 32'h0, 32'h0, 32'h0, 32'h0000_9003, 3'b000, 1'b0, 1'b0, 1'b1);
    chk("R9 target", next_pc, 32'h0000_9002);
    chk("R10 jalr misaligned", {31'b0, misalign}, 32'h1);
  endtask

  task automatic t_misalign();
    drive(32'h0000_1000, 32'h1, 32'h1, 32'h0000_0006, 32'h0, 3'b000, 1'b1, 1'b0, 1'b0);
    chk("R10 taken branch", {31'b0, misalign}, 32'h1);
    chk("R10 taken branch pc", next_pc, 32'h0000_1006);
    drive(32'h0000_1000, 32'h1, 32'h2, 32'h0000_0006, 32'h0, 3'b000, 1'b1, 1'b0, 1'b0);
    chk("R10 untaken branch", {31'b0, misalign}, 32'h0);
    chk("R10 untaken pc", next_pc, 32'h0000_1004);
    drive(32'h0000_1000, 32'h0, 32'h0, 32'h0000_0002, 32'h0, 3'b000, 1'b0, 1'b1, 1'b0);
    chk("R10 jal", {31'b0, misalign}, 32'h1);
  endtask

  task automatic t_priority();
    drive(32'h0000_1000, 32'h1, 32'h1, 32'h0000_0100, 32'h0000_8000, 3'b000, 1'b1, 1'b1, 1'b1);
    chk("R11 jalr first", next_pc, 32'h0000_8000);
    drive(32'h0000_1000, 32'h1, 32'h2, 32'h0000_0100, 32'h0000_8000, 3'b000, 1'b1, 1'b1, 1'b0);
    chk("R11 jal over untaken branch", next_pc, 32'h0000_1100);
    chk("R11 taken", {31'b0, taken}, 32'h1);
  endtask

  initial begin
    pc = '0; rs1 = '0; rs2 = '0; imm = '0; alu = '0; f3 = '0;
    isb = 1'b0; isj = 1'b0; isjr = 1'b0;
    t_reset_state();
    t_sequential();
    t_equality();
    t_signed();
    t_unsigned();
    t_taken_target();
    t_reserved();
    t_jal();
    t_jalr();
    t_misalign();
    t_priority();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule